// File: doc/BRIEF.md
# AAD-Multiplexed Parallel Bus Target

This block is the target side of a 16-bit multiplexed NOR-style parallel bus that runs in address-address-data mode. The host has no dedicated address pins here. Every address bit reaches the target over the shared 16-bit AD bus, in two address phases. Each phase is closed by a rising edge of the active-low address-valid strobe. The upper part of the word address comes first and the lower part second. After the two address phases, the same pins carry one 16-bit data word.

The target rebuilds the 27-bit word address, which spans host address bits 27 down to 1. Bit 0 never travels because the bus addresses 16-bit words. The block then serves a single read or write through a plain internal register port. It decodes chip select, output enable and write enable to decide when it may drive the AD bus.

Everything is sampled on the bus clock. The host may produce that clock by dividing its functional clock with a 2-bit divider setting, and the block does not care which setting is used. A programmable-logic bridge would use this block to sit behind such a host.

Top module: `aad_bus_target`

## Requirements
- R1: After reset, `reg_wr` and `proto_err` are 0 and `reg_addr` is 0.
- R2: On the first address-valid rising edge (`adv_n` seen 0 on one clock and 1 on the next) while `cs_n` is low, AD[10:0] becomes `reg_addr[26:16]` (host address bits 27..17). AD[15:11] in that phase have no effect.
- R3: On the second such edge, AD[15:0] becomes `reg_addr[15:0]` (host address bits 16..1), so `reg_addr` = upper*65536 + lower.
- R4: Whenever `cs_n` is sampled high, the phase count returns to the upper phase. The next cycle therefore starts with the upper address again.
- R5: In the data phase with `cs_n` low, the first clock that samples `we_n` low captures AD[15:0]. On the following cycle `reg_wr` is 1 for exactly one cycle, with `reg_wdata` holding that word and `reg_addr` holding the assembled address. Holding `we_n` low longer produces no further strobe.
- R6: A `we_n` low before both address phases have completed produces no `reg_wr`.
- R7: `ad_oe` is 1 exactly when `cs_n` and `oe_n` are both 0. `ad_out` carries `reg_rdata`, which is looked up at `reg_addr`.
- R8: A third address-valid rising edge within one chip-select window raises `proto_err` for exactly one cycle and leaves `reg_addr` unchanged.
- R9: An address-valid rising edge while `cs_n` is high does not change `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| adv_n | input | 1 | Active-low address-valid strobe |
| oe_n | input | 1 | Active-low output enable (read) |
| we_n | input | 1 | Active-low write enable |
| ad_in | input | 16 | AD bus value seen at the pins |
| ad_out | output | 16 | Read data to drive onto the AD bus |
| ad_oe | output | 1 | Drive enable for the AD pads; bus is tri-stated when 0 |
| reg_addr | output | 27 | Assembled word address (host bits 27..1) |
| reg_wr | output | 1 | One-cycle internal write strobe |
| reg_wdata | output | 16 | Captured write word |
| reg_rdata | input | 16 | Read word returned by the register port for `reg_addr` |
| proto_err | output | 1 | One-cycle pulse on a surplus address phase |

## Verification
A sweep of 48 write-then-read transactions varies the upper and lower address words and the data word together. Junk is placed in AD[15:11] during the upper phase, so the sweep separates a correct 11-bit upper field from one taken with the wrong width or position. A swap of the two halves shows up as a wrong `reg_addr`. Each read returns a word computed from the full address, so any mis-assembled bit changes `ad_out`.

Separate sequences cover the remaining rules:
- A chip-select drop after one phase shows whether the phase count restarts.
- A write enable asserted early shows whether writes are gated by the phase.
- A surplus strobe shows that the error pulse fires and that the address is held.
- Strobes with chip select high show that the address is not disturbed.
- All four chip-select and output-enable combinations show when the AD bus may be driven.

// File: rtl/aad_pkg.sv
package aad_pkg;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned UPPER_W = 11;

  typedef enum logic [1:0] {
    PH_UPPER = 2'd0,
    PH_LOWER = 2'd1,
    PH_DATA  = 2'd2
  } aad_phase_t;

  function automatic aad_phase_t phase_step(input aad_phase_t p);
    case (p)
      PH_UPPER: return PH_LOWER;
      PH_LOWER: return PH_DATA;
      default:  return PH_DATA;
    endcase
  endfunction
endpackage

// File: rtl/aad_phase_ctl.sv
module aad_phase_ctl
  import aad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       adv_n,
  output aad_phase_t phase,
  output logic       upper_ld,
  output logic       lower_ld,
  output logic       proto_err
);
  logic       adv_q;
  logic       adv_rise;
  logic       live_rise;
  logic       surplus;
  aad_phase_t phase_q;
  logic       err_q;

  assign adv_rise  = adv_n & ~adv_q;
  assign live_rise = adv_rise & ~cs_n;
  assign upper_ld  = live_rise && (phase_q == PH_UPPER);
  assign lower_ld  = live_rise && (phase_q == PH_LOWER);
  assign surplus   = live_rise && (phase_q == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_q   <= 1'b1;
      phase_q <= PH_UPPER;
      err_q   <= 1'b0;
    end else begin
      adv_q <= adv_n;
      err_q <= surplus;
      if (cs_n)
        phase_q <= PH_UPPER;
      else if (live_rise && phase_q != PH_DATA)
        phase_q <= phase_step(phase_q);
    end
  end

  assign phase     = phase_q;
  assign proto_err = err_q;

  // R4
  cs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase_q == PH_UPPER));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  // R8
  err_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (phase_q == PH_DATA));
endmodule

// File: rtl/aad_addr_asm.sv
module aad_addr_asm #(
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned UPPER_W = 11,
  localparam int unsigned ADDR_W = BUS_W + UPPER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upper_ld,
  input  logic              lower_ld,
  input  logic [BUS_W-1:0]  ad_in,
  output logic [ADDR_W-1:0] addr
);
  logic [UPPER_W-1:0] upper_q;
  logic [BUS_W-1:0]   lower_q;

  function automatic logic [ADDR_W-1:0] word_addr(
    input logic [UPPER_W-1:0] up,
    input logic [BUS_W-1:0]   lo
  );
    return {up, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
    end else begin
      if (upper_ld) upper_q <= ad_in[UPPER_W-1:0];
      if (lower_ld) lower_q <= ad_in;
    end
  end

  assign addr = word_addr(upper_q, lower_q);

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upper_ld, lower_ld}));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lower_ld |=> $stable(upper_q));
endmodule

// File: rtl/aad_wr_cap.sv
module aad_wr_cap #(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             in_data,
  input  logic [BUS_W-1:0] ad_in,
  output logic             wr,
  output logic [BUS_W-1:0] wdata
);
  logic we_q;
  logic we_fall;
  logic take;
  logic wr_q;

  assign we_fall = ~we_n & we_q;
  assign take    = we_fall & ~cs_n & in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q  <= 1'b1;
      wr_q  <= 1'b0;
      wdata <= '0;
    end else begin
      we_q <= we_n;
      wr_q <= take;
      if (take) wdata <= ad_in;
    end
  end

  assign wr = wr_q;

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R6
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(in_data));
endmodule

// File: rtl/aad_bus_target.sv
module aad_bus_target
  import aad_pkg::*;
#(
  parameter int unsigned BUS_W   = aad_pkg::BUS_W,
  parameter int unsigned UPPER_W = aad_pkg::UPPER_W,
  localparam int unsigned ADDR_W = BUS_W + UPPER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [BUS_W-1:0]  ad_in,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [BUS_W-1:0]  reg_wdata,
  input  logic [BUS_W-1:0]  reg_rdata,
  output logic              proto_err
);
  aad_phase_t phase;
  logic       upper_ld;
  logic       lower_ld;
  logic       in_data;

  aad_phase_ctl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .adv_n    (adv_n),
    .phase    (phase),
    .upper_ld (upper_ld),
    .lower_ld (lower_ld),
    .proto_err(proto_err)
  );

  aad_addr_asm #(.BUS_W(BUS_W), .UPPER_W(UPPER_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upper_ld(upper_ld),
    .lower_ld(lower_ld),
    .ad_in   (ad_in),
    .addr    (reg_addr)
  );

  assign in_data = (phase == PH_DATA);

  aad_wr_cap #(.BUS_W(BUS_W)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .we_n   (we_n),
    .in_data(in_data),
    .ad_in  (ad_in),
    .wr     (reg_wr),
    .wdata  (reg_wdata)
  );

  assign ad_oe  = ~cs_n & ~oe_n;
  assign ad_out = reg_rdata;

  // R8
  err_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $stable(reg_addr));

  // R9
  idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> $stable(reg_addr));
endmodule

// File: tb/test_aad_bus_target.sv
`timescale 1ns/1ps
module test_aad_bus_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [26:0] reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        proto_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rd_model(input logic [26:0] a);
    int unsigned v;
    v = ((a % 65536) ^ ((a / 2048) % 65536)) + 23100;
    return 16'(v % 65536);
  endfunction

  function automatic logic [26:0] exp_addr(input logic [15:0] up, input logic [15:0] lo);
    return 27'((up % 2048) * 65536 + lo);
  endfunction

  assign reg_rdata = rd_model(reg_addr);

  aad_bus_target i_aad_bus_target (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic adv_pulse(input logic [15:0] v);
    @(negedge clk); ad_in = v; adv_n = 1'b0;
    @(negedge clk); adv_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic open_cs();
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic close_cs();
    @(negedge clk); cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [26:0] ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr", {31'd0, reg_wr}, 32'd0);
    chk("R1 err", {31'd0, proto_err}, 32'd0);
    chk("R1 addr", {5'd0, reg_addr}, 32'd0);
    chk("R7 idle oe", {31'd0, ad_oe}, 32'd0);

    // R2 R3 R5 R7 sweep
    for (int i = 0; i < 48; i++) begin
      logic [15:0] up, lo, d;
      up = 16'((i * 7 % 32) * 2048 + (i * 683 + i * i * 13) % 2048);
      lo = 16'((i * 1543 + 11) % 65536);
      d  = 16'((i * 40503 + 777) % 65536);
      ea = exp_addr(up, lo);
      open_cs();
      adv_pulse(up);
      adv_pulse(lo);
      @(negedge clk); ad_in = d; we_n = 1'b0;
      @(negedge clk);
      chk("R5 strobe", {31'd0, reg_wr}, 32'd1);
      chk("R2/R3 addr", {5'd0, reg_addr}, {5'd0, ea});
      chk("R5 data", {16'd0, reg_wdata}, {16'd0, d});
      @(negedge clk);
      chk("R5 single", {31'd0, reg_wr}, 32'd0);
      we_n = 1'b1;
      @(negedge clk); oe_n = 1'b0; #1;
      chk("R7 drive", {31'd0, ad_oe}, 32'd1);
      chk("R7 rdata", {16'd0, ad_out}, {16'd0, rd_model(ea)});
      @(negedge clk); oe_n = 1'b1; #1;
      chk("R7 release", {31'd0, ad_oe}, 32'd0);
      close_cs();
    end

    // R7 cs high, oe low
    @(negedge clk); cs_n = 1'b1; oe_n = 1'b0; #1;
    chk("R7 cs off", {31'd0, ad_oe}, 32'd0);
    oe_n = 1'b1;

    // R9 strobes with cs high
    ea = reg_addr;
    adv_pulse(16'h07AB);
    adv_pulse(16'h1234);
    chk("R9 hold", {5'd0, reg_addr}, {5'd0, ea});

    // R4 restart after partial cycle
    open_cs();
    adv_pulse(16'h0555);
    close_cs();
    open_cs();
    adv_pulse(16'h0123);
    adv_pulse(16'hBEEF);
    chk("R4 restart", {5'd0, reg_addr}, {5'd0, exp_addr(16'h0123, 16'hBEEF)});
    close_cs();

    // R6 early write enable
    open_cs();
    adv_pulse(16'h0456);
    @(negedge clk); ad_in = 16'hAAAA; we_n = 1'b0;
    @(negedge clk);
    chk("R6 early", {31'd0, reg_wr}, 32'd0);
    we_n = 1'b1;
    adv_pulse(16'h7890);
    chk("R6 after", {31'd0, reg_wr}, 32'd0);

    // R8 surplus strobe
    ea = exp_addr(16'h0456, 16'h7890);
    adv_pulse(16'hFFFF);
    chk("R8 err", {31'd0, proto_err}, 32'd1);
    chk("R8 addr", {5'd0, reg_addr}, {5'd0, ea});
    @(negedge clk);
    chk("R8 pulse", {31'd0, proto_err}, 32'd0);
    ad_in = 16'h5151; we_n = 1'b0;
    @(negedge clk);
    chk("R8 write ok", {31'd0, reg_wr}, 32'd1);
    chk("R8 write addr", {5'd0, reg_addr}, {5'd0, ea});
    close_cs();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule